// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This controller loads a bitstream into a downstream FPGA over a byte-wide slave parallel port. A start pulse launches the whole power-up handshake in hardware. The program request is held for a minimum number of cycles and kept on until the target reports that its init line is asserted. The request is then released, and the controller waits for init to clear. Chip-select and write are raised only after that. A settling delay follows before the first byte is offered.

Bytes come from an upstream source through a valid/ready handshake. A byte-count input, sampled at start, sets how many bytes are sent. Each byte is placed on the bus, and the configuration clock is driven low and then high, each phase stretched to a parameterised number of cycles. The target latches the byte on the rising edge.

Three conditions are checked between bytes:
- If done rises early, streaming stops and the final check is made. This is not an error.
- If init is asserted again, the target has seen a configuration error such as a CRC mismatch. The load aborts.
- If the optional busy check is built in, a high busy line holds back the next byte.

Every wait is limited by its own cycle-count timeout. The outcome is reported as a one-cycle pass pulse or a one-cycle fail pulse, and the controller then returns to idle.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After reset, and while idle, all of the following hold: program low, chip-select low, write low, data-bus enable low, ready low, pass low, fail low, configuration clock high.
- R2: After start, program stays high for at least PROG_CYC cycles. It is released without a fail only after cfg_init_i has been seen high (1 = init asserted).
- R3: If cfg_init_i does not rise while program is held, fail pulses after exactly PROG_CYC + INIT_TO cycles of program high.
- R4: After program is released, the controller waits for cfg_init_i to return low. If it does not within INIT_TO cycles, fail pulses and no byte is sent.
- R5: Chip-select and write rise only after cfg_init_i has been seen low. Ready first rises exactly SETTLE_CYC cycles after chip-select rises.
- R6: Each accepted byte, in the order accepted, is driven on cfg_data_o. The clock is held low for exactly PHASE_CYC cycles, then rises while the data stays stable across the rising edge.
- R7: If cfg_done_i rises during streaming, no further byte is accepted and pass pulses.
- R8: If cfg_init_i rises during streaming, no further byte is accepted, fail pulses, and chip-select, write and the bus enable drop.
- R9: While cfg_busy_i is high after a byte, the clock does not fall for the next byte. If busy stays high for BUSY_TO cycles, fail pulses.
- R10: After the last byte, chip-select and write drop. Pass pulses once cfg_done_i is high and cfg_init_i is low. If that does not happen within CONF_TO cycles, fail pulses.
- R11: Pass and fail are one-cycle pulses, never both high, followed by idle. A start pulse during a load is ignored.
- R12: A byte count of zero accepts no byte and goes straight to the final done check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (sampled when idle) |
| byte_cnt_i | input | CNT_W | Number of bytes to send, sampled at start |
| s_data_i | input | DATA_W | Upstream byte |
| s_valid_i | input | 1 | Upstream byte valid |
| s_ready_o | output | 1 | Byte accepted this cycle when valid |
| cfg_prog_o | output | 1 | Program request to target, 1 = asserted |
| cfg_init_i | input | 1 | Target init line, 1 = asserted |
| cfg_done_i | input | 1 | Target done line, 1 = configured |
| cfg_busy_i | input | 1 | Target busy, 1 = hold next byte |
| cfg_cs_o | output | 1 | Chip-select, 1 = selected |
| cfg_wr_o | output | 1 | Write enable, 1 = write |
| cfg_cclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | DATA_W | Configuration data bus |
| cfg_data_oe_o | output | 1 | Data bus drive enable |
| pass_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
The bench builds the block with small timing values:

| Parameter | Value |
|---|---|
| Clock phase | 2 cycles |
| Program pulse | 4 cycles |
| Settle | 5 cycles |
| Init timeout | 20 cycles |
| Busy timeout | 12 cycles |
| Config timeout | 30 cycles |
| Busy check | built in |

With these values every timeout expires within a few dozen cycles, so each abort path and its exact cycle count can be reached. A behavioural target model answers program with init, raises done after the expected byte, and can inject each fault:
- a missing init;
- a stuck init;
- a mid-stream init (CRC error);
- an early done;
- a short busy stretch and a stuck busy;
- a missing done.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_PGM, ST_PGM_WAIT, ST_INIT_CLR, ST_SETTLE, ST_FEED,
    ST_CLK_LO, ST_CLK_HI, ST_BUSY, ST_FINISH, ST_PASS, ST_ABORT
  } ld_state_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfg_step_timer.sv
module cfg_step_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == lim_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (!hit_o) cnt_q <= cnt_q + W'(1);
endmodule

// File: rtl/cfg_byte_ctr.sv
module cfg_byte_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         empty_o
);
  logic [W-1:0] left_q;

  assign empty_o = (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                 left_q <= '0;
    else if (load_i)             left_q <= val_i;
    else if (dec_i && !empty_o)  left_q <= left_q - W'(1);
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader import cfg_loader_pkg::*; #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PHASE_CYC  = 2,
  parameter int unsigned PROG_CYC   = 32,
  parameter int unsigned SETTLE_CYC = 1000,
  parameter int unsigned INIT_TO    = 50_000_000,
  parameter int unsigned BUSY_TO    = 500_000,
  parameter int unsigned CONF_TO    = 20_000_000,
  parameter bit          BUSY_CHECK = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  output logic              cfg_prog_o,
  input  logic              cfg_init_i,
  input  logic              cfg_done_i,
  input  logic              cfg_busy_i,
  output logic              cfg_cs_o,
  output logic              cfg_wr_o,
  output logic              cfg_cclk_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              cfg_data_oe_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int unsigned LIM_MAX = umax(umax(umax(PHASE_CYC, PROG_CYC), umax(SETTLE_CYC, INIT_TO)),
                                         umax(BUSY_TO, CONF_TO));
  localparam int unsigned TMR_W   = $clog2(LIM_MAX + 1);

  ld_state_e         state_q, state_d, hi_next;
  logic [TMR_W-1:0]  lim;
  logic              hit, empty, take;
  logic [DATA_W-1:0] data_q;

  if (BUSY_CHECK) begin : g_busy_chk
    assign hi_next = ST_BUSY;
  end else begin : g_no_busy_chk
    assign hi_next = ST_FEED;
  end

  always_comb begin
    case (state_q)
      ST_PGM:                   lim = TMR_W'(PROG_CYC);
      ST_PGM_WAIT, ST_INIT_CLR: lim = TMR_W'(INIT_TO);
      ST_SETTLE:                lim = TMR_W'(SETTLE_CYC);
      ST_CLK_LO, ST_CLK_HI:     lim = TMR_W'(PHASE_CYC);
      ST_BUSY:                  lim = TMR_W'(BUSY_TO);
      ST_FINISH:                lim = TMR_W'(CONF_TO);
      default:                  lim = TMR_W'(1);
    endcase
  end

  assign s_ready_o = (state_q == ST_FEED) && !cfg_done_i && !cfg_init_i && !empty;
  assign take      = s_ready_o && s_valid_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_PGM;
      ST_PGM:      if (hit) state_d = ST_PGM_WAIT;
      ST_PGM_WAIT: if (cfg_init_i) state_d = ST_INIT_CLR;
                   else if (hit) state_d = ST_ABORT;
      ST_INIT_CLR: if (!cfg_init_i) state_d = ST_SETTLE;
                   else if (hit) state_d = ST_ABORT;
      ST_SETTLE:   if (hit) state_d = ST_FEED;
      ST_FEED:     if (cfg_done_i) state_d = ST_FINISH;   // early done exit, not an error
                   else if (cfg_init_i) state_d = ST_ABORT; // target flagged a load error
                   else if (empty) state_d = ST_FINISH;
                   else if (s_valid_i) state_d = ST_CLK_LO;
      ST_CLK_LO:   if (hit) state_d = ST_CLK_HI;
      ST_CLK_HI:   if (hit) state_d = hi_next;
      ST_BUSY:     if (!cfg_busy_i) state_d = ST_FEED;
                   else if (hit) state_d = ST_ABORT;
      ST_FINISH:   if (cfg_done_i && !cfg_init_i) state_d = ST_PASS;
                   else if (hit) state_d = ST_ABORT;
      ST_PASS, ST_ABORT: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (take) data_q <= s_data_i;
    end

  cfg_step_timer #(.W(TMR_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_d != state_q),
    .lim_i  (lim),
    .hit_o  (hit)
  );

  cfg_byte_ctr #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  ((state_q == ST_IDLE) && start_i),
    .val_i   (byte_cnt_i),
    .dec_i   (take),
    .empty_o (empty)
  );

  always_comb begin
    cfg_cs_o = state_q inside {ST_SETTLE, ST_FEED, ST_CLK_LO, ST_CLK_HI, ST_BUSY};
  end
  assign cfg_wr_o      = cfg_cs_o;
  assign cfg_data_oe_o = cfg_cs_o;
  assign cfg_data_o    = data_q;
  assign cfg_prog_o    = (state_q == ST_PGM) || (state_q == ST_PGM_WAIT);
  assign cfg_cclk_o    = (state_q != ST_CLK_LO);
  assign pass_o        = (state_q == ST_PASS);
  assign fail_o        = (state_q == ST_ABORT);

  assert_prog_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_prog_o) && !fail_o |-> $past(cfg_init_i));
  assert_cs_after_init_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_cs_o) |-> $past(!cfg_init_i));
  assert_data_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_cclk_o) && cfg_cs_o |-> $stable(cfg_data_o));
  assert_pass_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(cfg_done_i && !cfg_init_i));
  assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_o, fail_o}));
  assert_pulse_short_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |=> !(pass_o || fail_o));
endmodule

// File: tb/fpga_cfg_loader_test.sv
module fpga_cfg_loader_test;
  localparam int CLK_NS = 10;
  localparam int PHASE = 2, PROG = 4, SETTLE = 5, INIT_TO = 20, BUSY_TO = 12, CONF_TO = 30;
  localparam int M_NORM = 0, M_EARLY = 1, M_CRC = 2, M_BUSYSH = 3, M_BUSYSTK = 4,
                 M_NODONE = 5, M_NOINIT = 6, M_STUCK = 7;
  localparam int NSC = 10;
  localparam int SC_MODE [NSC] = '{M_NORM, M_NORM, M_EARLY, M_CRC, M_BUSYSH, M_BUSYSTK, M_NODONE, M_NOINIT, M_STUCK, M_NORM};
  localparam int SC_N    [NSC] = '{6, 0, 8, 8, 5, 5, 4, 4, 4, 6};
  localparam int SC_K    [NSC] = '{0, 0, 3, 2, 0, 0, 0, 0, 0, 0};
  localparam int SC_OK   [NSC] = '{1, 1, 1, 0, 1, 0, 0, 0, 0, 1};
  localparam int SC_LAT  [NSC] = '{6, 0, 3, 2, 5, 1, 4, 0, 0, 6};
  localparam int SC_POKE [NSC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1};

  logic clk = 0, rst_ni = 0, start_i = 0, s_valid_i = 0;
  logic [7:0] byte_cnt_i = 0, s_data_i;
  logic s_ready_o, cfg_prog_o, cfg_cs_o, cfg_wr_o, cfg_cclk_o, cfg_data_oe_o, pass_o, fail_o;
  logic cfg_init_i = 0, cfg_done_i = 0, cfg_busy_i = 0;
  logic [7:0] cfg_data_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  int mode, n_tgt, k_tgt, seed;
  int pc, rc, latched, acc, busy_left, data_err, low_err, busy_err, lo_run;
  int prog_hi, prog_rise, settle_cnt, settle_seen;
  bit cleared, cclk_prev, cs_prev, prog_prev, in_settle;

  always #(CLK_NS/2) clk = ~clk;

  fpga_cfg_loader #(
    .DATA_W(8), .CNT_W(8), .PHASE_CYC(PHASE), .PROG_CYC(PROG), .SETTLE_CYC(SETTLE),
    .INIT_TO(INIT_TO), .BUSY_TO(BUSY_TO), .CONF_TO(CONF_TO), .BUSY_CHECK(1'b1)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .cfg_prog_o(cfg_prog_o), .cfg_init_i(cfg_init_i), .cfg_done_i(cfg_done_i),
    .cfg_busy_i(cfg_busy_i), .cfg_cs_o(cfg_cs_o), .cfg_wr_o(cfg_wr_o),
    .cfg_cclk_o(cfg_cclk_o), .cfg_data_o(cfg_data_o), .cfg_data_oe_o(cfg_data_oe_o),
    .pass_o(pass_o), .fail_o(fail_o)
  );

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 37 + s * 11 + 5) & 255);
  endfunction

  assign s_data_i = pat(acc, seed);

  // upstream handshake counted on the same edge the design samples
  always @(posedge clk) if (s_ready_o && s_valid_i) acc <= acc + 1;

  // target model and monitors, away from the active edge
  always @(negedge clk) begin
    if (cfg_prog_o) begin
      pc++; prog_hi++;
      if (!prog_prev) prog_rise++;
      if (pc >= 2 && mode != M_NOINIT) cfg_init_i <= 1'b1;
      cfg_done_i <= 1'b0;
    end else if (pc > 0 && !cleared) begin
      rc++;
      if (rc >= 3 && mode != M_STUCK) begin cfg_init_i <= 1'b0; cleared = 1; end
    end
    if (cfg_cs_o && !cs_prev) begin in_settle = 1; settle_cnt = 0; end
    if (in_settle) begin
      if (s_ready_o) begin settle_seen = settle_cnt; in_settle = 0; end
      else settle_cnt++;
    end
    if (cfg_cs_o && !cfg_cclk_o) begin
      if (cclk_prev && cfg_busy_i) busy_err++;
      lo_run++;
    end
    if (cfg_cs_o && cfg_cclk_o && !cclk_prev) begin
      if (lo_run != PHASE) low_err++;
      lo_run = 0;
      if (cfg_data_o != pat(latched, seed)) data_err++;
      latched++;
      if (mode == M_BUSYSH) busy_left = 3;
      if (mode == M_BUSYSTK) cfg_busy_i <= 1'b1;
    end
    if (mode == M_BUSYSH) begin
      if (busy_left > 0) begin cfg_busy_i <= 1'b1; busy_left--; end
      else cfg_busy_i <= 1'b0;
    end
    if (cleared && mode == M_CRC && latched >= k_tgt) cfg_init_i <= 1'b1;
    if (cleared && mode != M_NODONE && mode != M_CRC &&
        latched >= ((mode == M_EARLY) ? k_tgt : n_tgt)) cfg_done_i <= 1'b1;
    cclk_prev = cfg_cclk_o; cs_prev = cfg_cs_o; prog_prev = cfg_prog_o;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model(int m, int n, int k, int s);
    mode = m; n_tgt = n; k_tgt = k; seed = s;
    pc = 0; rc = 0; latched = 0; acc = 0; busy_left = 0; data_err = 0; low_err = 0;
    busy_err = 0; lo_run = 0; prog_hi = 0; prog_rise = 0; settle_seen = -1; in_settle = 0;
    cleared = 0; cfg_init_i = 0; cfg_done_i = 0; cfg_busy_i = 0;
  endtask

  task automatic check_idle(string req);
    chk(!cfg_prog_o && !cfg_cs_o && !cfg_wr_o && !cfg_data_oe_o && !s_ready_o &&
        !pass_o && !fail_o && cfg_cclk_o, req,
        {cfg_prog_o, cfg_cs_o, cfg_wr_o, cfg_data_oe_o, s_ready_o, pass_o, fail_o, cfg_cclk_o},
        8'b0000_0001);
  endtask

  task automatic run_sc(int i);
    int got = -1;
    @(negedge clk);
    clear_model(SC_MODE[i], SC_N[i], SC_K[i], i);
    byte_cnt_i = 8'(SC_N[i]); s_valid_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      start_i = (SC_POKE[i] != 0 && c == 40);
      if (pass_o || fail_o) begin got = pass_o; break; end
    end
    start_i = 0;
    chk(got == SC_OK[i], "R7/R8/R9/R10 outcome", got, SC_OK[i]);
    chk(latched == SC_LAT[i], "R6/R7/R8 bytes clocked", latched, SC_LAT[i]);
    chk(acc == SC_LAT[i], "R7/R8/R12 bytes accepted", acc, SC_LAT[i]);
    chk(data_err == 0, "R6 data order", data_err, 0);
    chk(low_err == 0, "R6 low phase length", low_err, 0);
    chk(busy_err == 0, "R9 clock fell under busy", busy_err, 0);
    chk(prog_hi >= PROG, "R2 program pulse width", prog_hi, PROG);
    if (SC_LAT[i] > 0) chk(settle_seen == SETTLE, "R5 settle before first ready", settle_seen, SETTLE);
    if (SC_MODE[i] == M_NOINIT) chk(prog_hi == PROG + INIT_TO, "R3 init timeout length", prog_hi, PROG + INIT_TO);
    if (SC_MODE[i] == M_STUCK) chk(settle_seen == -1, "R4 no select on stuck init", settle_seen, -1);
    if (SC_POKE[i] != 0) chk(prog_rise == 1, "R11 start ignored while busy", prog_rise, 1);
    @(negedge clk);
    check_idle("R11 idle after result pulse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst_ni = 1;
    @(negedge clk);
    check_idle("R1 idle after reset");
    for (int i = 0; i < NSC; i++) run_sc(i);
    // R12 row above (count 0); reset mid-stream returns all pins to idle (R1)
    @(negedge clk);
    clear_model(M_NORM, 6, 0, 3);
    byte_cnt_i = 8'd6; s_valid_i = 1; start_i = 1;
    @(negedge clk);
    start_i = 0;
    for (int c = 0; c < 500 && latched < 2; c++) @(negedge clk);
    chk(cfg_cs_o == 1'b1, "R5 selected while streaming", cfg_cs_o, 1);
    rst_ni = 0;
    @(negedge clk);
    check_idle("R1 reset mid-stream");
    rst_ni = 1;
    @(negedge clk);
    check_idle("R1 idle after mid-stream reset");
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule